// File: doc/BRIEF.md
# Display-Controller I2C Command and Data Receiver

This block is the serial front-end of a display controller. It watches an oversampled I2C clock and data line, finds START and STOP conditions, and decodes the first byte of each transfer. That byte holds a six-bit device code, a register-select flag and a direction flag. When the code matches, the block acknowledges by pulling the data line low. It then passes every following byte to the controller core as a one-cycle write strobe, tagged as either a command byte or a display-memory byte.

In the read direction the block sends display-memory bytes to the master. The first two bytes sent after the address are filler: the block releases the line, so the master sees all ones, and it makes no fetch. From the third byte on, the block takes each byte from a one-cycle fetch port. A master NACK ends the read.

The bus pins are sampled by the system clock through two-stage synchronizers. The system clock must run at least eight times faster than SCL. The only bus output is an open-drain pull-down enable.

Top module: `disp_i2c_rx`

## Requirements
- R1: SDA falling while SCL is high (START) begins address reception from any state. SDA rising while SCL is high (STOP) returns the block to idle with SDA released. A byte clocked in idle without a START gets no acknowledge and gives no strobe.
- R2: The first byte is received MSB first. Bits 7..3 must equal 01110, bit 2 must equal `id_pin`, bit 1 is the register-select flag and bit 0 is the direction flag (1 = read). On a match, `sda_drive_low` is high during the ninth clock.
- R3: An address whose code does not match, or whose select/direction pair is 0/1, gets no acknowledge. The block then stays off the bus, ignores every byte and makes no strobe until the next START.
- R4: After a matched write address, each 8-bit byte gives exactly one single-cycle `wr_stb` with the byte on `wr_data` and the address's select flag on `wr_rs`, and it is acknowledged in the ninth clock. `wr_stb` and `rd_req` are never high together.
- R5: In a read, the first two bytes sent after the address are dummy bytes. SDA stays released for them (the master reads 0xFF) and no fetch is made.
- R6: From the third read byte on, each byte is preceded by one single-cycle `rd_req`. `rd_data` is captured on the clock edge that ends that pulse and sent MSB first.
- R7: `sda_drive_low` changes only while the synchronized SCL is low. The block releases SDA for the master's acknowledge bit. After a master NACK it drives nothing and fetches nothing until the next START.
- R8: A START that arrives partway through a byte discards the partial byte without a strobe, and address reception restarts.
- R9: While `rst_n` is low, `sda_drive_low`, `wr_stb` and `rd_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| id_pin | input | 1 | Lowest bit of the device code |
| sda_drive_low | output | 1 | Open-drain enable: 1 pulls SDA low |
| wr_stb | output | 1 | One-cycle strobe for a received byte |
| wr_rs | output | 1 | 0 = command byte, 1 = display-memory byte |
| wr_data | output | 8 | Received byte |
| rd_req | output | 1 | One-cycle fetch request for the next read byte |
| rd_data | input | 8 | Fetched byte, captured at the end of the `rd_req` cycle |

## Verification
The end of an acknowledge slot and the loading of the next outgoing read byte happen on the same SCL falling edge. For fetched bytes, the fetch request and the ACK hand-off also share that cycle. Reads of random length, with master ACKs and a final NACK, are mixed with writes and bad addresses to provoke this overlap. Every returned byte is compared against a model of two dummies followed by the fetch sequence, and the fetch requests are counted per transfer.

// File: rtl/disp_i2c_pkg.sv
package disp_i2c_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_MACK,
        ST_SKIP
    } rx_state_t;

endpackage

// File: rtl/disp_i2c_sync.sv
module disp_i2c_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar g = 0; g < W; g++) begin : g_line
        logic [STAGES-1:0] sh;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= '1;
            else        sh <= {sh[STAGES-2:0], d[g]};
        end
        assign q[g] = sh[STAGES-1];
    end
endmodule

// File: rtl/disp_i2c_cond.sv
module disp_i2c_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/disp_i2c_rx.sv
module disp_i2c_rx
    import disp_i2c_pkg::*;
#(
    parameter int              BYTE_W      = 8,
    parameter int              SYNC_STAGES = 2,
    parameter int              DUMMY_BYTES = 2,
    parameter logic [BYTE_W-4:0] CODE_HI   = 5'b01110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              id_pin,
    output logic              sda_drive_low,
    output logic              wr_stb,
    output logic              wr_rs,
    output logic [BYTE_W-1:0] wr_data,
    output logic              rd_req,
    input  logic [BYTE_W-1:0] rd_data
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam int DCW   = $clog2(DUMMY_BYTES + 1);
    localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(BYTE_W - 1);
    localparam logic [DCW-1:0]   DUMMY_LIM = DCW'(DUMMY_BYTES);

    logic scl_s, sda_s;
    logic scl_rise, scl_fall, start_det, stop_det;

    disp_i2c_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_i, sda_i}),
        .q     ({scl_s, sda_s})
    );

    disp_i2c_cond u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    rx_state_t state, state_n;

    logic [BYTE_W-1:0] rx_sh, tx_sh, nb;
    logic [CNT_W-1:0]  bit_cnt;
    logic [DCW-1:0]    dummy_cnt;
    logic              done_q, adr_ok_q, rs_q, rw_q, nack_q, pend;
    logic              drv_q, stb_q, req_q, rs_out_q;
    logic [BYTE_W-1:0] data_q;
    logic              do_load, adr_match;

    assign nb        = {rx_sh[BYTE_W-2:0], sda_s};
    assign adr_match = (nb[BYTE_W-1:2] == {CODE_HI, id_pin}) && (nb[1:0] != 2'b01);
    assign do_load   = scl_fall && ((state == ST_ADDR_ACK && rw_q) ||
                                    (state == ST_RD_MACK && !nack_q));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // next-state logic
    always_comb begin
        state_n = state;
        if (start_det) begin
            state_n = ST_ADDR;
        end else if (stop_det) begin
            state_n = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     state_n = ST_IDLE;
                ST_ADDR:     if (scl_fall && done_q) state_n = adr_ok_q ? ST_ADDR_ACK : ST_SKIP;
                ST_ADDR_ACK: if (scl_fall) state_n = rw_q ? ST_RD : ST_WR;
                ST_WR:       if (scl_fall && done_q) state_n = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall) state_n = ST_WR;
                ST_RD:       if (scl_fall && done_q) state_n = ST_RD_MACK;
                ST_RD_MACK:  if (scl_fall) state_n = nack_q ? ST_SKIP : ST_RD;
                ST_SKIP:     state_n = ST_SKIP;
                default:     state_n = ST_IDLE;
            endcase
        end
    end

    // datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sh     <= '0;
            tx_sh     <= '1;
            bit_cnt   <= '0;
            dummy_cnt <= '0;
            done_q    <= 1'b0;
            adr_ok_q  <= 1'b0;
            rs_q      <= 1'b0;
            rw_q      <= 1'b0;
            nack_q    <= 1'b0;
            pend      <= 1'b0;
            drv_q     <= 1'b0;
            stb_q     <= 1'b0;
            req_q     <= 1'b0;
            rs_out_q  <= 1'b0;
            data_q    <= '0;
        end else begin
            stb_q <= 1'b0;
            req_q <= 1'b0;
            if (start_det || stop_det) begin
                bit_cnt   <= '0;
                dummy_cnt <= '0;
                done_q    <= 1'b0;
                nack_q    <= 1'b0;
                pend      <= 1'b0;
                drv_q     <= 1'b0;
                tx_sh     <= '1;
            end else begin
                unique case (state)
                    ST_ADDR: begin
                        if (scl_rise) begin
                            rx_sh   <= nb;
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt == LAST_BIT) begin
                                done_q   <= 1'b1;
                                adr_ok_q <= adr_match;
                                rs_q     <= nb[1];
                                rw_q     <= nb[0];
                            end
                        end else if (scl_fall && done_q) begin
                            drv_q   <= adr_ok_q;
                            done_q  <= 1'b0;
                            bit_cnt <= '0;
                        end
                    end
                    ST_ADDR_ACK, ST_WR_ACK: begin
                        if (scl_fall) drv_q <= 1'b0;
                    end
                    ST_WR: begin
                        if (scl_rise) begin
                            rx_sh   <= nb;
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt == LAST_BIT) begin
                                done_q   <= 1'b1;
                                stb_q    <= 1'b1;
                                data_q   <= nb;
                                rs_out_q <= rs_q;
                            end
                        end else if (scl_fall && done_q) begin
                            drv_q   <= 1'b1;
                            done_q  <= 1'b0;
                            bit_cnt <= '0;
                        end
                    end
                    ST_RD: begin
                        if (pend) begin
                            tx_sh <= rd_data;
                            drv_q <= ~rd_data[BYTE_W-1];
                            pend  <= 1'b0;
                        end else if (scl_rise) begin
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt == LAST_BIT) done_q <= 1'b1;
                        end else if (scl_fall) begin
                            if (done_q) begin
                                drv_q   <= 1'b0;
                                done_q  <= 1'b0;
                                bit_cnt <= '0;
                            end else begin
                                tx_sh <= {tx_sh[BYTE_W-2:0], 1'b1};
                                drv_q <= ~tx_sh[BYTE_W-2];
                            end
                        end
                    end
                    ST_RD_MACK: begin
                        if (scl_rise) nack_q <= sda_s;
                    end
                    default: ;
                endcase
                if (do_load) begin
                    tx_sh <= '1;
                    drv_q <= 1'b0;
                    if (dummy_cnt < DUMMY_LIM) begin
                        dummy_cnt <= dummy_cnt + 1'b1;
                    end else begin
                        req_q <= 1'b1;
                        pend  <= 1'b1;
                    end
                end
            end
        end
    end

    // outputs
    always_comb begin
        sda_drive_low = drv_q;
        wr_stb        = stb_q;
        wr_rs         = rs_out_q;
        wr_data       = data_q;
        rd_req        = req_q;
    end
endmodule

// File: rtl/disp_i2c_rx_chk.sv
module disp_i2c_rx_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_s,
    input logic start_det,
    input logic stop_det,
    input logic sda_drive_low,
    input logic wr_stb,
    input logic rd_req
);
    AST_RESET_RELEASED: assert property (@(posedge clk)
        !rst_n |=> (!sda_drive_low && !wr_stb && !rd_req)); // R9

    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_drive_low); // R1

    AST_WR_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb); // R4

    AST_STB_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && rd_req)); // R4

    AST_RD_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req); // R6

    AST_SDA_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_drive_low != $past(sda_drive_low)) |-> !$past(scl_s)); // R7

    AST_START_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (!wr_stb && !rd_req)); // R8
endmodule

bind disp_i2c_rx disp_i2c_rx_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_s         (scl_s),
    .start_det     (start_det),
    .stop_det      (stop_det),
    .sda_drive_low (sda_drive_low),
    .wr_stb        (wr_stb),
    .rd_req        (rd_req)
);

// File: tb/disp_i2c_rx_bench.sv
module disp_i2c_rx_bench;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic scl_m = 1'b1, sda_m = 1'b1, id_pin = 1'b0;
    logic sda_drive_low, wr_stb, wr_rs, rd_req, sda_line;
    logic [7:0] wr_data, rd_data;
    int n_checks = 0, n_errors = 0, rq_cnt = 0, wr_cnt = 0, drv_cnt = 0;
    logic [7:0] wlog_d [256];
    logic       wlog_rs[256];

    function automatic logic [7:0] fetch_fn(int n);
        logic [7:0] v;
        v = 8'(n * 37 + 11);
        return v ^ 8'h5A;
    endfunction

    function automatic logic addr_ok(logic [7:0] a, logic id);
        return (a[7:3] == 5'b01110) && (a[2] == id) && (a[1:0] != 2'b01);
    endfunction

    assign sda_line = sda_m & ~sda_drive_low;
    assign rd_data  = fetch_fn(rq_cnt);

    disp_i2c_rx u_disp_i2c_rx (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .id_pin(id_pin),
        .sda_drive_low(sda_drive_low), .wr_stb(wr_stb), .wr_rs(wr_rs), .wr_data(wr_data),
        .rd_req(rd_req), .rd_data(rd_data)
    );

    always @(posedge clk) begin
        if (wr_stb) begin
            wlog_d[wr_cnt % 256]  <= wr_data;
            wlog_rs[wr_cnt % 256] <= wr_rs;
            wr_cnt <= wr_cnt + 1;
        end
        if (rd_req) rq_cnt <= rq_cnt + 1;
        if (sda_drive_low) drv_cnt <= drv_cnt + 1;
    end

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        scl_m = 1'b0; tick(Q);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(2);
    endtask

    task automatic i2c_stop();
        scl_m = 1'b0; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic write_bit(input logic b);
        tick(2); sda_m = b; tick(Q - 2);
        scl_m = 1'b1; tick(Q);
        scl_m = 1'b0;
    endtask

    task automatic read_bit(output logic v);
        tick(2); sda_m = 1'b1; tick(Q - 2);
        scl_m = 1'b1; tick(Q / 2);
        v = sda_line; tick(Q / 2);
        scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic v;
        for (int i = 7; i >= 0; i--) write_bit(b[i]);
        read_bit(v);
        acked = ~v;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        logic v;
        for (int i = 7; i >= 0; i--) begin
            read_bit(v);
            b[i] = v;
        end
        write_bit(~mack);
    endtask

    task automatic xfer_write(input logic [7:0] addr, input int nb);
        logic a, ok;
        logic [7:0] d;
        int w0, dv0;
        ok  = addr_ok(addr, id_pin);
        w0  = wr_cnt;
        dv0 = drv_cnt;
        i2c_start();
        send_byte(addr, a);
        check(a == ok, ok ? "R2" : "R3", "address ack", int'(a), int'(ok));
        for (int i = 0; i < nb; i++) begin
            d = 8'($urandom);
            send_byte(d, a);
            if (ok) begin
                check(a == 1'b1, "R4", "data ack", int'(a), 1);
                check(wr_cnt == w0 + i + 1, "R4", "strobe count", wr_cnt, w0 + i + 1);
                check(wlog_d[(w0 + i) % 256] == d && wlog_rs[(w0 + i) % 256] == addr[1],
                      "R4", "byte/flag", int'({wlog_rs[(w0 + i) % 256], wlog_d[(w0 + i) % 256]}),
                      int'({addr[1], d}));
            end else begin
                check(a == 1'b0 && wr_cnt == w0, "R3", "ignored byte", wr_cnt, w0);
            end
        end
        if (!ok) check(drv_cnt == dv0, "R3", "no drive after mismatch", drv_cnt, dv0);
        i2c_stop();
        check(!sda_drive_low, "R1", "released after stop", int'(sda_drive_low), 0);
    endtask

    task automatic xfer_read(input int nb);
        logic a;
        logic [7:0] v, e;
        int q0, dv0;
        i2c_start();
        send_byte({5'b01110, id_pin, 2'b11}, a);
        check(a == 1'b1, "R2", "read address ack", int'(a), 1);
        q0 = rq_cnt;
        for (int k = 0; k < nb; k++) begin
            recv_byte(k != nb - 1, v);
            if (k < 2) begin
                check(v == 8'hFF, "R5", "dummy byte", int'(v), 255);
            end else begin
                e = fetch_fn(q0 + k - 2);
                check(v == e, "R6", "fetched byte", int'(v), int'(e));
            end
        end
        e = 8'(nb > 2 ? nb - 2 : 0);
        check(rq_cnt == q0 + int'(e), "R6", "fetch count", rq_cnt - q0, int'(e));
        q0  = rq_cnt;
        dv0 = drv_cnt;
        recv_byte(1'b0, v);
        check(v == 8'hFF && rq_cnt == q0 && drv_cnt == dv0, "R7", "silent after NACK",
              int'(v), 255);
        i2c_stop();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin : main
        logic a;
        logic [7:0] d, ad;
        int w0, dv0, mode;
        void'($urandom(32'd4021));
        tick(10);
        check(!sda_drive_low && !wr_stb && !rd_req, "R9", "reset outputs",
              int'({sda_drive_low, wr_stb, rd_req}), 0);
        rst_n = 1'b1;
        tick(10);

        id_pin = 1'b0; xfer_write(8'h70, 3);
        id_pin = 1'b1; xfer_write(8'h76, 3);
        xfer_write(8'h72, 2);
        xfer_write(8'h75, 2);
        xfer_read(5);
        xfer_read(1);

        // R8: partial byte discarded by repeated START
        id_pin = 1'b0;
        i2c_start();
        send_byte(8'h70, a);
        w0 = wr_cnt;
        write_bit(1'b1); write_bit(1'b0); write_bit(1'b1);
        i2c_start();
        send_byte(8'h72 ^ 8'h02, a);
        check(a == 1'b1, "R8", "address after restart", int'(a), 1);
        send_byte(8'h3C, a);
        check(wr_cnt == w0 + 1 && wlog_d[w0 % 256] == 8'h3C, "R8", "single full byte",
              wr_cnt - w0, 1);
        i2c_stop();

        // R1: no START, byte ignored
        w0 = wr_cnt; dv0 = drv_cnt;
        send_byte(8'h70, a);
        check(a == 1'b0 && wr_cnt == w0 && drv_cnt == dv0, "R1", "idle ignores byte",
              int'(a), 0);
        i2c_stop();

        for (int it = 0; it < 24; it++) begin
            id_pin = 1'($urandom);
            mode = int'($urandom % 4);
            case (mode)
                0: xfer_write({5'b01110, id_pin, 2'b00}, 1 + int'($urandom % 4));
                1: xfer_write({5'b01110, id_pin, 2'b10}, 1 + int'($urandom % 4));
                2: xfer_read(1 + int'($urandom % 6));
                default: begin
                    ad = 8'($urandom);
                    if (addr_ok(ad, id_pin)) ad = ad ^ 8'h80;
                    xfer_write(ad, 2);
                end
            endcase
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule